// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block controls a direct-mapped cache whose lines each hold a single 32-bit word. Tag and data storage live in an external synchronous RAM with a one-cycle read latency. The controller drives that RAM's index, compares the returned tag against the request, and keeps a valid bit for every line in its own flops. A load that hits returns the cached word. A load that misses stalls the requester. While the requester is stalled, the controller waits for all buffered stores to reach memory, reads the word from memory, writes the word and its tag into the RAM, and returns the word.

Every store is written through to memory. The store goes into a four-entry FIFO store buffer, which empties over a request/acknowledge memory port. The requester is held only while that buffer is full. A store that hits also updates the cached word under its byte-enable mask. A store that misses leaves the RAM untouched.

The requester presents a request and holds it. The request completes on the clock edge where `req_i` is high and `stall_o` is low. Load data on `rdata_o` is valid in that same cycle.

Top module: `wt_cache_ctrl`

## Requirements
- R1: The RAM index is address bits [IDX_W+1:2]. The tag is always the full address bits [31:12], with IDX_W between 10 and 18. Two addresses with the same index and different tags evict each other.
- R2: After reset every line is invalid. A load to a line whose stored tag happens to match still misses. With no request, `stall_o` and `mem_req_o` are low.
- R3: A load that hits completes after one stall cycle. It returns the RAM data word and issues no memory read.
- R4: A load that misses stalls the requester. It reads the word-aligned address from memory with byte enables 4'b1111 and writes the word and tag into the RAM. It marks the line valid and returns the memory word in the cycle of the acknowledge.
- R5: A store that hits merges its data into the cached word. Byte b of the word (bits 8b+7:8b) is replaced where byte-enable bit b is 1.
- R6: A store that misses does not write the RAM (no write allocation).
- R7: Every store reaches memory through the store buffer, in program order, with its own byte address, byte enables and data.
- R8: A store completes after one stall cycle while the buffer has room. When four stores are waiting, a new store stalls until memory accepts one of them.
- R9: The memory read for a miss is issued only after the store buffer is empty, so a load never returns stale data.
- R10: A memory request keeps its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until completion |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| be_i | input | 4 | Store byte enables |
| wdata_i | input | 32 | Store data |
| stall_o | output | 1 | Request not yet complete |
| rdata_o | output | 32 | Load data, valid on the completing cycle |
| ram_en_o | output | 1 | Tag/data RAM enable |
| ram_we_o | output | 1 | Tag/data RAM write |
| ram_idx_o | output | IDX_W | Tag/data RAM index |
| ram_tag_o | output | 20 | Tag to write |
| ram_wdata_o | output | 32 | Data word to write |
| ram_tag_i | input | 20 | Tag read, one cycle after enable |
| ram_rdata_i | input | 32 | Data read, one cycle after enable |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_be_o | output | 4 | Memory byte enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |

## Verification
The assertions check several properties on every cycle:
- a miss read never goes out while the store buffer holds entries;
- memory requests stay stable until acknowledged;
- the store buffer is never pushed when full or popped when empty;
- a completed fill leaves the line valid;
- a store-side RAM write only happens when the stored tag matches.

Only the bench scenarios can show the data-level behaviour: byte-merge results, the set of loads that miss after reset or eviction, the order and contents of written-through stores, and the stall lengths seen by the requester. These scenarios compare against a reference memory updated at each store.

// File: rtl/wt_cache_pkg.sv
`timescale 1ns/1ps
package wt_cache_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 20;
  localparam int BE_W   = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } sb_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_DRAIN,
    ST_FILL
  } ctrl_state_e;
endpackage

// File: rtl/wt_byte_merge.sv
`timescale 1ns/1ps
module wt_byte_merge #(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] merged_o
);
  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign merged_o[b*8 +: 8] = be_i[b] ? new_i[b*8 +: 8] : old_i[b*8 +: 8];
  end
endmodule

// File: rtl/wt_valid_bits.sv
`timescale 1ns/1ps
module wt_valid_bits #(
  parameter int IDX_W = 10,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             valid_o,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i
);
  logic [LINES-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    v_q <= '0;
    else if (set_i) v_q[set_idx_i] <= 1'b1;
  end

  assign valid_o = v_q[rd_idx_i];
endmodule

// File: rtl/wt_store_buf.sv
`timescale 1ns/1ps
module wt_store_buf
  import wt_cache_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  sb_entry_t entry_i,
  input  logic      pop_i,
  output sb_entry_t head_o,
  output logic      empty_o,
  output logic      full_o
);
  sb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wr_q] <= entry_i;
  end

  assign head_o  = slot_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_count_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/wt_cache_ctrl.sv
`timescale 1ns/1ps
module wt_cache_ctrl
  import wt_cache_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int SB_DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [31:0]        addr_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  output logic               stall_o,
  output logic [31:0]        rdata_o,
  output logic               ram_en_o,
  output logic               ram_we_o,
  output logic [IDX_W-1:0]   ram_idx_o,
  output logic [19:0]        ram_tag_o,
  output logic [31:0]        ram_wdata_o,
  input  logic [19:0]        ram_tag_i,
  input  logic [31:0]        ram_rdata_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [31:0]        mem_addr_o,
  output logic [3:0]         mem_be_o,
  output logic [31:0]        mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [31:0]        mem_rdata_i
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;
  localparam int TAG_LO = ADDR_W - TAG_W;

  ctrl_state_e       state_q, state_d;
  logic              a_we_q;
  logic [ADDR_W-1:0] a_addr_q;
  logic [BE_W-1:0]   a_be_q;
  logic [DATA_W-1:0] a_wdata_q;

  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic              line_valid, hit;
  logic              sb_push, sb_pop, sb_empty, sb_full;
  sb_entry_t         sb_in, sb_head;
  logic [DATA_W-1:0] merged;
  logic              fill_rd, fill_done;

  assign a_idx = a_addr_q[IDX_HI:IDX_LO];
  assign a_tag = a_addr_q[ADDR_W-1:TAG_LO];
  assign hit   = line_valid && (ram_tag_i == a_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      a_we_q    <= 1'b0;
      a_addr_q  <= '0;
      a_be_q    <= '0;
      a_wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i) begin
        a_we_q    <= we_i;
        a_addr_q  <= addr_i;
        a_be_q    <= be_i;
        a_wdata_q <= wdata_i;
      end
    end
  end

  assign fill_rd   = (state_q == ST_FILL);
  assign fill_done = fill_rd && mem_ack_i;

  always_comb begin
    state_d = state_q;
    stall_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        stall_o = req_i;
        if (req_i) state_d = ST_LOOK;
      end
      ST_LOOK: begin
        if (a_we_q) begin
          stall_o = sb_full;
          if (!sb_full) state_d = ST_IDLE;
        end else begin
          stall_o = !hit;
          state_d = hit ? ST_IDLE : ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        stall_o = 1'b1;
        if (sb_empty) state_d = ST_FILL;
      end
      ST_FILL: begin
        stall_o = !mem_ack_i;
        if (mem_ack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rdata_o = fill_rd ? mem_rdata_i : ram_rdata_i;

  // the lookup index is re-read each cycle so a store held by a full buffer sees current data
  assign ram_en_o    = (state_q == ST_IDLE && req_i) || (state_q == ST_LOOK) || fill_done;
  assign ram_idx_o   = (state_q == ST_IDLE) ? addr_i[IDX_HI:IDX_LO] : a_idx;
  assign ram_we_o    = sb_push && hit || fill_done;
  assign ram_tag_o   = a_tag;
  assign ram_wdata_o = fill_rd ? mem_rdata_i : merged;

  wt_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_i    (ram_rdata_i),
    .new_i    (a_wdata_q),
    .be_i     (a_be_q),
    .merged_o (merged)
  );

  wt_valid_bits #(.IDX_W(IDX_W)) u_valid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (a_idx),
    .valid_o   (line_valid),
    .set_i     (fill_done),
    .set_idx_i (a_idx)
  );

  assign sb_push    = (state_q == ST_LOOK) && a_we_q && !sb_full;
  assign sb_in.addr = a_addr_q;
  assign sb_in.be   = a_be_q;
  assign sb_in.data = a_wdata_q;
  assign sb_pop     = !fill_rd && !sb_empty && mem_ack_i;

  wt_store_buf #(.DEPTH(SB_DEPTH)) u_sb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (sb_push),
    .entry_i (sb_in),
    .pop_i   (sb_pop),
    .head_o  (sb_head),
    .empty_o (sb_empty),
    .full_o  (sb_full)
  );

  assign mem_req_o   = fill_rd || !sb_empty;
  assign mem_we_o    = !fill_rd;
  assign mem_addr_o  = fill_rd ? {a_addr_q[ADDR_W-1:2], 2'b00} : sb_head.addr;
  assign mem_be_o    = fill_rd ? '1 : sb_head.be;
  assign mem_wdata_o = sb_head.data;

  p_read_after_drain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> sb_empty);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));
  p_fill_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> line_valid);
  p_store_hit_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && state_q == ST_LOOK) |-> (ram_tag_i == ram_tag_o));
endmodule

// File: tb/wt_cache_ctrl_bench.sv
`timescale 1ns/1ps
module wt_cache_ctrl_bench;
  localparam int IDX_W = 10;
  localparam int LINES = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0]  be = '0;
  logic        stall_o;
  logic [31:0] rdata_o;
  logic        ram_en, ram_we;
  logic [IDX_W-1:0] ram_idx;
  logic [19:0] ram_tag_w, ram_tag_r;
  logic [31:0] ram_wd, ram_rd;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wd, mem_rd;
  logic [3:0]  mem_be;

  int n_tests = 0, n_fail = 0;
  int rd_cnt = 0;
  bit hold_ack = 1'b0;
  int max_lat = 0;
  int dly = 0;

  always #2.5 clk = ~clk;

  wt_cache_ctrl #(.IDX_W(IDX_W)) u_wt_cache_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .stall_o(stall_o), .rdata_o(rdata_o),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_idx_o(ram_idx),
    .ram_tag_o(ram_tag_w), .ram_wdata_o(ram_wd), .ram_tag_i(ram_tag_r),
    .ram_rdata_i(ram_rd), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wd),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rd)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input logic [29:0] w);
    return {w[13:0], 2'b10, w[15:0]} ^ 32'hC3A5_1E0F;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = m[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  logic [31:0] mem_m [logic [29:0]];
  logic [31:0] ref_m [logic [29:0]];
  logic [67:0] exp_wq [$];

  function automatic logic [31:0] mem_get(input logic [29:0] w);
    return mem_m.exists(w) ? mem_m[w] : init_word(w);
  endfunction
  function automatic logic [31:0] ref_get(input logic [29:0] w);
    return ref_m.exists(w) ? ref_m[w] : init_word(w);
  endfunction

  // external tag/data RAM, one-cycle read latency
  logic [19:0] tram [LINES];
  logic [31:0] dram [LINES];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) begin
        tram[ram_idx] <= ram_tag_w;
        dram[ram_idx] <= ram_wd;
      end
      ram_tag_r <= tram[ram_idx];
      ram_rd    <= dram[ram_idx];
    end
  end

  // memory model with programmable latency
  logic [31:0] prev_addr;
  logic [31:0] prev_wd;
  logic        prev_wait = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      dly       = 0;
      prev_wait = 1'b0;
    end else begin
      if (prev_wait)
        chk(mem_req && mem_addr == prev_addr && mem_wd == prev_wd, "R10", mem_addr, prev_addr);
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req && !hold_ack) begin
        if (dly == 0) begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            logic [67:0] e;
            e = (exp_wq.size() > 0) ? exp_wq.pop_front() : '0;
            chk({mem_addr, mem_be, mem_wd} == e, "R7", mem_addr, e[67:36]);
            mem_m[mem_addr[31:2]] = merge(mem_get(mem_addr[31:2]), mem_wd, mem_be);
          end else begin
            rd_cnt++;
            chk(exp_wq.size() == 0, "R9", exp_wq.size(), 0);
            chk(mem_be == 4'hF && mem_addr[1:0] == 2'b00, "R4", {28'h0, mem_be}, 32'hF);
            mem_rd <= mem_get(mem_addr[31:2]);
          end
          dly = (max_lat > 0) ? $urandom_range(max_lat, 0) : 0;
        end else dly--;
      end
      prev_wait = mem_req && !mem_ack;
      prev_addr = mem_addr;
      prev_wd   = mem_wd;
    end
  end

  task automatic cpu_op(input bit w, input logic [31:0] a, input logic [3:0] m,
                        input logic [31:0] d, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = m; wdata = d;
    #0.5;
    cyc = 0;
    while (stall_o) begin
      @(negedge clk); #0.5;
      cyc++;
    end
    rd = rdata_o;
    @(posedge clk);
    if (w) begin
      ref_m[a[31:2]] = merge(ref_get(a[31:2]), d, m);
      exp_wq.push_back({a, m, d});
    end
    #1 req = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [19:0] t, input int i, input logic [1:0] o);
    return {t, i[IDX_W-1:0], o};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, a, b, e;
    logic [19:0] t0;
    logic [31:0] d0;
    int cyc, rc;
    void'($urandom(32'd1357));
    for (int i = 0; i < LINES; i++) begin
      tram[i] = '0;
      dram[i] = 32'hDEAD_BEEF;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!stall_o && !mem_req, "R2", {stall_o, mem_req}, 0);

    // R2: tag 0 matches RAM content but line is invalid
    a = mk(20'h0, 5, 0);
    rc = rd_cnt;
    cpu_op(0, a, 0, 0, r, cyc);
    chk(rd_cnt == rc + 1, "R2", rd_cnt - rc, 1);
    chk(r == ref_get(a[31:2]), "R2", r, ref_get(a[31:2]));

    // R3: hit
    rc = rd_cnt;
    cpu_op(0, a, 0, 0, r, cyc);
    chk(rd_cnt == rc && cyc == 1, "R3", cyc, 1);
    chk(r == ref_get(a[31:2]), "R3", r, ref_get(a[31:2]));

    // R1: full-tag compare, conflict eviction at same index
    a = mk(20'h00010, 7, 0);
    b = mk(20'h00011, 7, 0);
    cpu_op(0, a, 0, 0, r, cyc);
    rc = rd_cnt;
    cpu_op(0, b, 0, 0, r, cyc);
    chk(rd_cnt == rc + 1 && r == ref_get(b[31:2]), "R1", r, ref_get(b[31:2]));
    cpu_op(0, a, 0, 0, r, cyc);
    chk(rd_cnt == rc + 2 && r == ref_get(a[31:2]), "R1", rd_cnt - rc, 2);
    chk(tram[7] == 20'h00010, "R4", tram[7], 32'h10);

    // R5: partial store hit merges into cached word
    cpu_op(1, a + 32'd1, 4'b0110, 32'h1122_3344, r, cyc);
    e = ref_get(a[31:2]);
    chk(dram[7] == e, "R5", dram[7], e);
    rc = rd_cnt;
    cpu_op(0, a, 0, 0, r, cyc);
    chk(r == e && rd_cnt == rc, "R5", r, e);

    // R6: store miss leaves RAM untouched
    a = mk(20'h00ABC, 9, 0);
    t0 = tram[9];
    d0 = dram[9];
    cpu_op(1, a, 4'hF, 32'h5555_AAAA, r, cyc);
    repeat (3) @(posedge clk);
    chk(tram[9] == t0 && dram[9] == d0, "R6", dram[9], d0);
    cpu_op(0, a, 0, 0, r, cyc);
    chk(r == 32'h5555_AAAA, "R6", r, 32'h5555_AAAA);

    // R8: four stores proceed, fifth stalls until memory accepts one
    hold_ack = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cpu_op(1, mk(20'h00020, 40 + i, 0), 4'hF, 32'hA000_0000 + i, r, cyc);
      chk(cyc == 1, "R8", cyc, 1);
    end
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = mk(20'h00020, 44, 0); be = 4'hF; wdata = 32'hA000_0004;
    repeat (8) @(negedge clk);
    #0.5;
    chk(stall_o == 1'b1, "R8", stall_o, 1);
    hold_ack = 1'b0;
    while (stall_o) begin @(negedge clk); #0.5; end
    @(posedge clk);
    ref_m[addr[31:2]] = wdata;
    exp_wq.push_back({addr, be, wdata});
    #1 req = 1'b0;
    // R9: a miss right behind queued stores sees their data
    cpu_op(0, mk(20'h00020, 44, 0), 0, 0, r, cyc);
    chk(r == 32'hA000_0004, "R9", r, 32'hA000_0004);

    // random mix with variable memory latency
    max_lat = 3;
    for (int n = 0; n < 500; n++) begin
      logic [19:0] t;
      logic [3:0] m;
      bit w;
      case ($urandom_range(2, 0))
        0: t = 20'h00000;
        1: t = 20'h00001;
        default: t = 20'hABCDE;
      endcase
      a = mk(t, $urandom_range(7, 0), 2'($urandom_range(3, 0)));
      w = ($urandom_range(2, 0) == 0);
      case ($urandom_range(4, 0))
        0: m = 4'b0011;
        1: m = 4'b1100;
        2: m = 4'b0001 << $urandom_range(3, 0);
        default: m = 4'hF;
      endcase
      cpu_op(w, a, m, $urandom, r, cyc);
      if (!w) chk(r == ref_get(a[31:2]), "R3", r, ref_get(a[31:2]));
    end
    repeat (40) @(posedge clk);
    chk(exp_wq.size() == 0, "R7", exp_wq.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule